// File: doc/BRIEF.md
# Byte-Lane Bus Parity Generator/Checker

This block sits beside a 32-bit processor data bus and looks after one even-parity bit per byte lane. A bus cycle begins when `cyc_start` is seen while the block is idle. `cyc_write` gives the direction and `cyc_fill` marks a cache line fill. In a write cycle the block computes the parity of each write-data byte and drives the bits with the data, but only from the second clock of the cycle onward. In a read cycle the block samples the data and the incoming parity bits on every clock that has `rdy` high. In the following clock it shows an active-low error pulse on `perr_n` if any checked lane holds an odd number of ones.

A small state machine tracks the bus cycle. Its states are ST_IDLE, ST_WR_FIRST, ST_WR_DRIVE, ST_RD_FIRST and ST_RD_BURST, with these transitions:
- idle-to-write: ST_IDLE to ST_WR_FIRST on start with write.
- idle-to-read: ST_IDLE to ST_RD_FIRST on start with read.
- write-advance: ST_WR_FIRST to ST_WR_DRIVE, always.
- write-end: ST_WR_DRIVE to ST_IDLE on `rdy` with `xfer_last`.
- read-burst: ST_RD_FIRST to ST_RD_BURST on `rdy` without `xfer_last`.
- read-end: either read state to ST_IDLE on `rdy` with `xfer_last`.
- Every other case leaves the state unchanged.

The set of checked lanes is built from three things: the active-low byte enables, the bus-size inputs, and the first-beat-of-fill rule. Parity results are status only and never change the bus cycle.

Top module: `bus_parity_unit`

## Requirements
- R1: On writes, `dpar_out[n]` is the XOR of `dbus[8n+7:8n]`, so each byte together with its parity bit holds an even number of ones.
- R2: `dpar_oe` is low in the first clock of a write cycle. It is high from the second clock until the cycle ends on `rdy` with `xfer_last`. `dpar_out` reads 0 whenever `dpar_oe` is low.
- R3: `rdy` in the first clock of a write cycle is ignored, and the cycle goes on to drive parity.
- R4: In the clock after a read beat (`rdy` high in a read state), `perr_n` is 0 exactly when some checked lane has an odd count of ones over its 8 data bits plus `dpar_in[n]`.
- R5: `perr_n` is 1 in every clock that does not directly follow a read beat, including after `rdy` seen when idle or during a write.
- R6: `lane_en_n[n]` is active low and enables lane n. A disabled lane never causes an error.
- R7: `size8` (which takes priority) limits checking to lane 0. `size16` limits it to lanes 0 and 1. With neither asserted, all four lanes are eligible.
- R8: On the first beat of a fill cycle, every byte enable is treated as active, while bus size still applies. Later beats use `lane_en_n`.
- R9: Synchronous reset returns the machine to ST_IDLE, drops `dpar_oe` and sets `perr_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cyc_start | input | 1 | Bus cycle start, accepted in ST_IDLE |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle, sampled with start |
| cyc_fill | input | 1 | Cycle is a cache line fill, sampled with start |
| rdy | input | 1 | Transfer ready strobe |
| xfer_last | input | 1 | Marks the last transfer of the cycle when `rdy` is high |
| lane_en_n | input | 4 | Active-low byte enables, bit n for lane n |
| size8 | input | 1 | 8-bit bus width for the current transfer |
| size16 | input | 1 | 16-bit bus width for the current transfer |
| dbus | input | 32 | Data bus (write data or returned read data) |
| dpar_in | input | 4 | Parity bits returned with read data |
| dpar_out | output | 4 | Generated write parity bits |
| dpar_oe | output | 1 | Drive enable for `dpar_out` |
| perr_n | output | 1 | Active-low parity error status |

## Verification
The bench drives a `rdy` in the first write clock. A design that treated it as the end of the cycle would never raise `dpar_oe`. It sends bad parity on lanes that the byte enables or the bus size exclude, which catches a mask that is missing or reversed, and it also sends bad parity on lanes that are checked. A fill burst with every enable off shows whether the first-beat override is applied, and whether it is wrongly kept for the second beat. Back-to-back beats, a stray `rdy` while idle, and a reset in the middle of a write drive check that the error output is a single-clock pulse tied only to read beats, and that reset clears the drive.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_FIRST = 3'd1,
        ST_WR_DRIVE = 3'd2,
        ST_RD_FIRST = 3'd3,
        ST_RD_BURST = 3'd4
    } bus_state_e;

endpackage

// File: rtl/bpar_lane_gen.sv
module bpar_lane_gen #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic [BUS_W-1:0] data,
    output logic [LANES-1:0] par
);

    // One XOR tree per lane: even parity bit equals the lane's own XOR.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign par[i] = ^data[i*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/bpar_lane_check.sv
module bpar_lane_check #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic [BUS_W-1:0] data,
    input  logic [LANES-1:0] par_in,
    output logic [LANES-1:0] lane_bad
);

    // A lane is bad when its data plus parity bit holds an odd count of ones.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bad[i] = ^{data[i*LANE_W +: LANE_W], par_in[i]};
    end

endmodule

// File: rtl/bpar_lane_mask.sv
module bpar_lane_mask #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] en_n,
    input  logic             size8,
    input  logic             size16,
    input  logic             fill_first,
    output logic [LANES-1:0] mask
);

    logic [LANES-1:0] size_ok;
    logic [LANES-1:0] en_eff;

    // Per-lane width limit: 8-bit wins over 16-bit, neither means full width.
    for (genvar i = 0; i < LANES; i++) begin : g_size
        if (i == 0) begin : g_l0
            assign size_ok[i] = 1'b1;
        end else if (i == 1) begin : g_l1
            assign size_ok[i] = ~size8;
        end else begin : g_hi
            assign size_ok[i] = ~size8 & ~size16;
        end
    end

    // First beat of a line fill treats every enable as active.
    assign en_eff = fill_first ? {LANES{1'b1}} : ~en_n;
    assign mask   = en_eff & size_ok;

    AST_SIZE8_LANE0: assert property (@(posedge clk) disable iff (rst)
        size8 |-> (mask[LANES-1:1] == '0)) else $error("size8 mask"); // R7

    AST_FILL_ALL: assert property (@(posedge clk) disable iff (rst)
        (fill_first && !size8 && !size16) |-> (&mask)) else $error("fill mask"); // R8

    AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (rst)
        !fill_first |-> ((mask & en_n) == '0)) else $error("disabled lane"); // R6

endmodule

// File: rtl/bpar_seq.sv
module bpar_seq
    import bpar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic cyc_write,
    input  logic cyc_fill,
    input  logic rdy,
    input  logic xfer_last,
    output logic drive_oe,
    output logic rd_beat,
    output logic fill_first
);

    bus_state_e state, state_nx;
    logic       fill_q;

    // State register and fill flag captured at cycle start.
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fill_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && cyc_start) begin
                fill_q <= cyc_fill & ~cyc_write;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc_start) begin
                    state_nx = cyc_write ? ST_WR_FIRST : ST_RD_FIRST;
                end
            end
            ST_WR_FIRST: state_nx = ST_WR_DRIVE;
            ST_WR_DRIVE: begin
                if (rdy && xfer_last) state_nx = ST_IDLE;
            end
            ST_RD_FIRST: begin
                if (rdy) state_nx = xfer_last ? ST_IDLE : ST_RD_BURST;
            end
            ST_RD_BURST: begin
                if (rdy && xfer_last) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state.
    always_comb begin
        drive_oe   = 1'b0;
        rd_beat    = 1'b0;
        fill_first = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_WR_FIRST: ;
            ST_WR_DRIVE: drive_oe = 1'b1;
            ST_RD_FIRST: begin
                rd_beat    = rdy;
                fill_first = fill_q;
            end
            ST_RD_BURST: rd_beat = rdy;
            default:     ;
        endcase
    end

    AST_OE_AFTER_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_oe) |-> ($past(state) == ST_WR_FIRST)) else $error("oe rise"); // R2

    AST_WR_FIRST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_FIRST) |=> (state == ST_WR_DRIVE)) else $error("wr advance"); // R3

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc_start,
    input  logic             cyc_write,
    input  logic             cyc_fill,
    input  logic             rdy,
    input  logic             xfer_last,
    input  logic [LANES-1:0] lane_en_n,
    input  logic             size8,
    input  logic             size16,
    input  logic [BUS_W-1:0] dbus,
    input  logic [LANES-1:0] dpar_in,
    output logic [LANES-1:0] dpar_out,
    output logic             dpar_oe,
    output logic             perr_n
);

    logic             drive_oe;
    logic             rd_beat;
    logic             fill_first;
    logic [LANES-1:0] gen_par;
    logic [LANES-1:0] lane_bad;
    logic [LANES-1:0] mask;
    logic             perr_q;

    bpar_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cyc_start  (cyc_start),
        .cyc_write  (cyc_write),
        .cyc_fill   (cyc_fill),
        .rdy        (rdy),
        .xfer_last  (xfer_last),
        .drive_oe   (drive_oe),
        .rd_beat    (rd_beat),
        .fill_first (fill_first)
    );

    bpar_lane_gen #(.LANES(LANES), .LANE_W(LANE_W)) u_gen (
        .data (dbus),
        .par  (gen_par)
    );

    bpar_lane_check #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
        .data     (dbus),
        .par_in   (dpar_in),
        .lane_bad (lane_bad)
    );

    bpar_lane_mask #(.LANES(LANES)) u_mask (
        .clk        (clk),
        .rst        (rst),
        .en_n       (lane_en_n),
        .size8      (size8),
        .size16     (size16),
        .fill_first (fill_first),
        .mask       (mask)
    );

    // Error status: pulse low for one clock after a failing read beat.
    always_ff @(posedge clk) begin
        if (rst) begin
            perr_q <= 1'b1;
        end else if (rd_beat) begin
            perr_q <= ~|(lane_bad & mask);
        end else begin
            perr_q <= 1'b1;
        end
    end

    assign dpar_oe  = drive_oe;
    assign dpar_out = drive_oe ? gen_par : '0;
    assign perr_n   = perr_q;

    AST_PERR_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(rd_beat)) else $error("stray error"); // R5

    AST_WR_EVEN: assert property (@(posedge clk) disable iff (rst)
        dpar_oe |-> ((^{dbus, dpar_out}) == 1'b0)) else $error("odd write"); // R1

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (perr_n && !dpar_oe)) else $error("reset state"); // R9

endmodule

// File: tb/bus_parity_unit_test.sv
module bus_parity_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cyc_start, cyc_write, cyc_fill, rdy, xfer_last;
    logic [3:0]  lane_en_n;
    logic        size8, size16;
    logic [31:0] dbus;
    logic [3:0]  dpar_in;
    logic [3:0]  dpar_out;
    logic        dpar_oe;
    logic        perr_n;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_parity_unit uut (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_write(cyc_write),
        .cyc_fill(cyc_fill), .rdy(rdy), .xfer_last(xfer_last),
        .lane_en_n(lane_en_n), .size8(size8), .size16(size16),
        .dbus(dbus), .dpar_in(dpar_in), .dpar_out(dpar_out),
        .dpar_oe(dpar_oe), .perr_n(perr_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Even parity per byte, from the requirement.
    function automatic logic [3:0] even_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    task automatic idle_inputs();
        cyc_start = 0; cyc_write = 0; cyc_fill = 0; rdy = 0; xfer_last = 0;
        lane_en_n = 4'hF; size8 = 0; size16 = 0; dbus = '0; dpar_in = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R9 perr_n", perr_n, 1);
        check("R9 oe", dpar_oe, 0);
        check("R2 par zero when idle", dpar_out, 0);
        // reset in the middle of write drive
        cyc_start = 1; cyc_write = 1; dbus = 32'h1;
        @(negedge clk); cyc_start = 0;
        @(negedge clk);
        check("R2 oe set before reset", dpar_oe, 1);
        rst = 1;
        @(negedge clk); rst = 0;
        check("R9 oe dropped by reset", dpar_oe, 0);
        check("R9 perr_n after reset", perr_n, 1);
        idle_inputs();
        @(negedge clk);
        check("R9 idle after reset", dpar_oe, 0);
    endtask

    task automatic t_write(input logic [31:0] d);
        @(negedge clk);
        cyc_start = 1; cyc_write = 1; dbus = d;
        @(negedge clk);
        cyc_start = 0;
        check("R2 oe low first clock", dpar_oe, 0);
        rdy = 1; xfer_last = 1;            // R3: must be ignored
        @(negedge clk);
        rdy = 0; xfer_last = 0;
        check("R3 oe high after early rdy", dpar_oe, 1);
        check("R1 write parity", dpar_out, even_par(d));
        @(negedge clk);
        check("R2 oe held", dpar_oe, 1);
        rdy = 1; xfer_last = 1;
        @(negedge clk);
        rdy = 0; xfer_last = 0;
        check("R2 oe low after end", dpar_oe, 0);
        check("R5 no error after write", perr_n, 1);
    endtask

    task automatic t_read(input string req, input logic [3:0] en_n, input logic s8,
                          input logic s16, input logic [31:0] d, input logic [3:0] p,
                          input logic exp_perr_n);
        @(negedge clk);
        cyc_start = 1; cyc_write = 0; cyc_fill = 0;
        @(negedge clk);
        cyc_start = 0;
        rdy = 1; xfer_last = 1; lane_en_n = en_n; size8 = s8; size16 = s16;
        dbus = d; dpar_in = p;
        @(negedge clk);
        idle_inputs();
        check(req, perr_n, exp_perr_n);
        @(negedge clk);
        check("R5 pulse one clock", perr_n, 1);
    endtask

    task automatic t_fill();
        logic [31:0] d;
        logic [3:0]  p;
        d = 32'hA5C3_0F11;
        p = even_par(d) ^ 4'b1000;          // lane 3 wrong
        @(negedge clk);
        cyc_start = 1; cyc_write = 0; cyc_fill = 1;
        @(negedge clk);
        cyc_start = 0; cyc_fill = 0;
        rdy = 1; xfer_last = 0; lane_en_n = 4'hF; dbus = d; dpar_in = p;
        @(negedge clk);
        check("R8 fill first beat all lanes", perr_n, 0);
        xfer_last = 1;                      // second beat, same data
        @(negedge clk);
        idle_inputs();
        check("R8 later beat uses enables", perr_n, 1);
        // fill first beat with size8: lane 3 still excluded
        @(negedge clk);
        cyc_start = 1; cyc_fill = 1;
        @(negedge clk);
        cyc_start = 0; cyc_fill = 0;
        rdy = 1; xfer_last = 1; size8 = 1; dbus = d; dpar_in = p;
        @(negedge clk);
        idle_inputs();
        check("R8 fill keeps size limit", perr_n, 1);
    endtask

    task automatic t_stray_ready();
        @(negedge clk);
        rdy = 1; xfer_last = 1; lane_en_n = 4'h0; dbus = 32'h1; dpar_in = 4'h0;
        @(negedge clk);
        idle_inputs();
        check("R5 ready while idle", perr_n, 1);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<20000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_write(32'h0000_0000);
        t_write(32'h0103_0700);
        t_write(32'hFFFF_FFFE);
        t_read("R4 clean read",           4'h0, 0, 0, 32'h1234_5678, even_par(32'h1234_5678), 1);
        t_read("R4 bad lane2 enabled",    4'h0, 0, 0, 32'h1234_5678, even_par(32'h1234_5678) ^ 4'b0100, 0);
        t_read("R6 bad lane2 disabled",   4'b0100, 0, 0, 32'h1234_5678, even_par(32'h1234_5678) ^ 4'b0100, 1);
        t_read("R6 bad lane0 enabled",    4'b1110, 0, 0, 32'hFFFF_FF01, even_par(32'hFFFF_FF01) ^ 4'b0001, 0);
        t_read("R7 size8 ignores lane1",  4'h0, 1, 0, 32'h0000_0300, 4'b0010 ^ even_par(32'h0000_0300), 1);
        t_read("R7 size8 checks lane0",   4'h0, 1, 0, 32'h0000_0001, 4'b0000, 0);
        t_read("R7 size16 ignores lane2", 4'h0, 0, 1, 32'h0001_0000, 4'b0000, 1);
        t_read("R7 size16 checks lane1",  4'h0, 0, 1, 32'h0000_0100, 4'b0000, 0);
        t_read("R7 size8 over size16",    4'h0, 1, 1, 32'h0000_0100, 4'b0000, 1);
        t_fill();
        t_stray_ready();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule